// File: doc/BRIEF.md
# Three-Key Sequence Access Gate

This block guards a protected information area behind one register that software can only write. Access is granted only after three specific 32-bit key words have been written to that register, one after another and in a fixed order. The block tracks how many keys of the sequence have been accepted so far. When the last key lands, it raises an enable output that the protected area uses to permit both reads and writes.

Once the area is open, the next write to the register closes it again, whatever value that write carries. That write does not count as the start of a new sequence. A wrong value in the middle of the sequence sends the tracker back to the start. If the wrong value happens to equal the first key, it is taken as a fresh first key. Reading the register never reveals anything: a read strobe is answered one cycle later with an all-zero word.

The register interface is a plain strobe interface. Every write and every read is accepted in the cycle its strobe is high, so there is no back-pressure. A status output reports the current sequence step.

Top module: `key_unlock_gate`

## Requirements
- R1: After reset, `region_en` is 0, `step` is 0 and `rd_valid` is 0.
- R2: Writes of 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 take `step` from 0 to 1, 2 and 3 in turn. Each step change is visible at the first rising clock edge after the write strobe is sampled.
- R3: `region_en` rises in the cycle after the write of the third key, and it is high exactly while `step` equals 3.
- R4: While `step` is 3, a write of any value, including a key value, sets `step` to 0 and clears `region_en` at the next edge. That write is never treated as the first key.
- R5: At step 1 or 2, a write whose value is not the next key returns `step` to 0. If that value equals the first key (0x3A7F5CA3), `step` becomes 1 instead.
- R6: At step 0, a write of any value other than the first key leaves `step` at 0.
- R7: A cycle with `wr_en` low leaves `step` and `region_en` unchanged, whatever is on `wr_data`.
- R8: A read strobe `rd_en` gives `rd_valid` high one cycle later with `rd_data` equal to zero, in every step. A read never changes `step` or `region_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the access-control register |
| wr_data | input | 32 | Write data (key candidate) |
| rd_en | input | 1 | Read strobe for the access-control register |
| rd_valid | output | 1 | Read response valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read response data, always zero |
| region_en | output | 1 | Access enable for the protected information area |
| step | output | 2 | Number of keys accepted so far (3 = open) |

## Verification
A wrong sequence state has no buffering to hide behind. It shows on `step` at the very next clock edge after the write that caused it, and it shows on `region_en` no later than the write that would complete or break the sequence. The vector walk therefore compares `step` and `region_en` after every cycle, including idle cycles. In this way a mis-taken transition, a missed restart on the first key, or a relock that counts as a first key appears within one cycle of the write. Reads are checked in the open state, where a leak of key or state data into `rd_data` would matter most.

// File: rtl/key_unlock_pkg.sv
package key_unlock_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_KEYS = 3;
  // Index 0 is the key that must be written first.
  localparam logic [NUM_KEYS-1:0][DATA_W-1:0] DEFAULT_KEYS = {
    32'h9608B2C1,
    32'hA1E34F20,
    32'h3A7F5CA3
  };
endpackage

// File: rtl/key_unlock_cmp.sv
module key_unlock_cmp #(
  parameter int DATA_W   = key_unlock_pkg::DATA_W,
  parameter int NUM_KEYS = key_unlock_pkg::NUM_KEYS,
  parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS = key_unlock_pkg::DEFAULT_KEYS
) (
  input  logic [DATA_W-1:0]   cand,
  output logic [NUM_KEYS-1:0] hit
);
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    assign hit[g] = (cand == KEYS[g]);
  end
endmodule

// File: rtl/key_unlock_seq.sv
module key_unlock_seq #(
  parameter int NUM_KEYS = key_unlock_pkg::NUM_KEYS,
  localparam int STEP_W  = $clog2(NUM_KEYS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_KEYS-1:0] hit,
  output logic [STEP_W-1:0]   step,
  output logic                open
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_KEYS);

  logic [STEP_W-1:0] step_q, step_d;
  logic              open_q;
  logic              want_hit;

  // Does the written word match the key expected at the current step?
  always_comb begin
    want_hit = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (step_q == STEP_W'(i)) want_hit = hit[i];
    end
  end

  always_comb begin
    if (!wr_en)              step_d = step_q;
    else if (step_q == LAST) step_d = '0;          // relock, never a first key
    else if (want_hit)       step_d = step_q + 1'b1;
    else if (hit[0])         step_d = STEP_W'(1);  // restart on first key
    else                     step_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      open_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (wr_en) open_q <= (step_d == LAST);
    end
  end

  assign step = step_q;
  assign open = open_q;
endmodule

// File: rtl/key_unlock_rdport.sv
module key_unlock_rdport #(
  parameter int DATA_W = key_unlock_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end
  // The register is write-only: its contents never reach the read path.
  assign rd_data = '0;
endmodule

// File: rtl/key_unlock_gate.sv
module key_unlock_gate #(
  parameter int DATA_W   = key_unlock_pkg::DATA_W,
  parameter int NUM_KEYS = key_unlock_pkg::NUM_KEYS,
  parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS = key_unlock_pkg::DEFAULT_KEYS,
  localparam int STEP_W  = $clog2(NUM_KEYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              region_en,
  output logic [STEP_W-1:0] step
);
  logic [NUM_KEYS-1:0] hit;

  key_unlock_cmp #(.DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)) u_cmp (
    .cand (wr_data),
    .hit  (hit)
  );

  key_unlock_seq #(.NUM_KEYS(NUM_KEYS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .hit   (hit),
    .step  (step),
    .open  (region_en)
  );

  key_unlock_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/key_unlock_gate_chk.sv
module key_unlock_gate_chk #(
  parameter int DATA_W   = key_unlock_pkg::DATA_W,
  parameter int NUM_KEYS = key_unlock_pkg::NUM_KEYS,
  parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS = key_unlock_pkg::DEFAULT_KEYS,
  localparam int STEP_W  = $clog2(NUM_KEYS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              region_en,
  input logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_KEYS);

  logic [DATA_W-1:0] next_key;
  always_comb begin
    next_key = KEYS[0];
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (step == STEP_W'(i)) next_key = KEYS[i];
    end
  end

  AST_KEY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && step != LAST && wr_data == next_key |=> step == $past(step) + 1'b1) else $error("key advance"); // R2

  AST_OPEN_MATCHES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    region_en == (step == LAST)) else $error("enable vs step"); // R3

  AST_OPEN_AFTER_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region_en) |-> $past(wr_en && wr_data == KEYS[NUM_KEYS-1])) else $error("open without last key"); // R3

  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && region_en |=> !region_en && step == '0) else $error("relock"); // R4

  AST_WRONG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && step != '0 && step != LAST && wr_data != next_key && wr_data != KEYS[0]
    |=> step == '0) else $error("wrong key restart"); // R5

  AST_WRONG_IS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && step != LAST && wr_data != next_key && wr_data == KEYS[0]
    |=> step == STEP_W'(1)) else $error("first key restart"); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(step) && $stable(region_en)) else $error("idle hold"); // R7

  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid && rd_data == '0) else $error("read response"); // R8
endmodule

bind key_unlock_gate key_unlock_gate_chk #(
  .DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_data(rd_data), .region_en(region_en), .step(step)
);

// File: tb/test_key_unlock_gate.sv
module test_key_unlock_gate;
  localparam logic [31:0] K0 = 32'h3A7F5CA3;
  localparam logic [31:0] K1 = 32'hA1E34F20;
  localparam logic [31:0] K2 = 32'h9608B2C1;
  localparam logic [31:0] JUNK = 32'h0000_0000;

  typedef struct packed {
    logic        wr;
    logic [31:0] d;
    logic [1:0]  st;
    logic        en;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, K0,   2'd1, 1'b0},  // R2 first key
    '{1'b1, K1,   2'd2, 1'b0},  // R2 second key
    '{1'b1, K2,   2'd3, 1'b1},  // R2 R3 open
    '{1'b1, K2,   2'd0, 1'b0},  // R4 relock with key value
    '{1'b1, K0,   2'd1, 1'b0},  // R2
    '{1'b1, JUNK, 2'd0, 1'b0},  // R5 wrong at step 1
    '{1'b1, K0,   2'd1, 1'b0},
    '{1'b1, K1,   2'd2, 1'b0},
    '{1'b1, K0,   2'd1, 1'b0},  // R5 wrong at step 2 is first key
    '{1'b1, K1,   2'd2, 1'b0},
    '{1'b1, JUNK, 2'd0, 1'b0},  // R5 wrong at step 2
    '{1'b1, K1,   2'd0, 1'b0},  // R6 second key at step 0
    '{1'b1, K0,   2'd1, 1'b0},
    '{1'b0, K1,   2'd1, 1'b0},  // R7 no strobe
    '{1'b1, K1,   2'd2, 1'b0},
    '{1'b0, K2,   2'd2, 1'b0},  // R7 no strobe
    '{1'b1, K2,   2'd3, 1'b1},  // R3
    '{1'b0, K0,   2'd3, 1'b1},  // R7 hold open
    '{1'b1, K0,   2'd0, 1'b0},  // R4 relock not a first key
    '{1'b1, K1,   2'd0, 1'b0}   // R4 follow-up proves step 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        region_en;
  logic [1:0]  step;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  key_unlock_gate i_key_unlock_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .region_en(region_en), .step(step)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_key(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset step", 32'(step), 32'd0);
    check("R1 reset enable", 32'(region_en), 32'd0);
    check("R1 reset rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 step after release", 32'(step), 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr;
      wr_data = VEC[i].d;
      @(negedge clk);
      check($sformatf("R2-vec%0d step", i), 32'(step), 32'(VEC[i].st));
      check($sformatf("R3-vec%0d enable", i), 32'(region_en), 32'(VEC[i].en));
    end
    wr_en = 1'b0;

    // R8: read while open returns zero and leaves state alone
    write_key(K0); write_key(K1); write_key(K2);
    check("R3 open before read", 32'(region_en), 32'd1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 rd_valid", 32'(rd_valid), 32'd1);
    check("R8 rd_data open", rd_data, 32'd0);
    check("R8 step after read", 32'(step), 32'd3);
    check("R8 enable after read", 32'(region_en), 32'd1);
    @(negedge clk);
    check("R8 rd_valid drops", 32'(rd_valid), 32'd0);

    // R8: read at mid-sequence step
    write_key(JUNK);
    write_key(K0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 rd_data step1", rd_data, 32'd0);
    check("R8 step kept at 1", 32'(step), 32'd1);

    // R1: reset while open clears everything
    write_key(K1); write_key(K2);
    check("R3 open again", 32'(region_en), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears enable", 32'(region_en), 32'd0);
    check("R1 reset clears step", 32'(step), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: first key repeated at step 1 stays at 1
    write_key(K0); write_key(K0);
    check("R5 repeated first key", 32'(step), 32'd1);

    // R6: third key at step 0 is ignored
    write_key(JUNK); write_key(K2);
    check("R6 third key from start", 32'(step), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule